// File: doc/BRIEF.md
# Condition Flag Compare Unit

This block produces the single true/false condition flag of a 32-bit processor core from one comparison. The datapath supplies a comparison selector, the two register operands `rn` and `rm`, the value of register zero and a raw 8-bit immediate. The unit returns the new flag value in the same cycle. It has no storage and no clock.

Every two-operand test asks how `rn` relates to `rm`, so "greater or equal" means `rn >= rm`. Magnitude tests come in two forms. The unsigned form treats the operands as plain binary numbers. The signed form treats them as two's complement and decides by the sign bits first, so `0x80000000` is the most negative value. The equality-with-immediate test always compares register zero against the immediate after sign extension. A byte-lane match test reports whether any of the four byte positions hold equal bytes in `rn` and `rm`. It is used to scan strings for a terminator or for a replicated search byte.

Top module: `cmpu_tflag`

## Requirements
- R1: `cmp_op` encodings are 0 immediate-equal, 1 equal, 2 unsigned higher-or-same, 3 signed greater-or-equal, 4 unsigned higher, 5 signed greater-than, 6 non-negative, 7 positive, 8 any-byte-match. Codes 9 to 15 give `t_out` = 0.
- R2: With code 1, `t_out` is 1 exactly when `rn` equals `rm`. Comparing a value with itself gives 1.
- R3: With code 0, `t_out` is 1 exactly when `r0` equals `imm8` sign-extended from bit 7 to 32 bits. `rn` and `rm` have no effect.
- R4: With code 2, `t_out` is 1 exactly when `rn` >= `rm` as unsigned numbers.
- R5: With code 4, `t_out` is 1 exactly when `rn` > `rm` as unsigned numbers. Comparing a value with itself gives 0.
- R6: With code 3, `t_out` is 1 exactly when `rn` >= `rm` as two's-complement numbers.
- R7: With code 5, `t_out` is 1 exactly when `rn` > `rm` as two's-complement numbers.
- R8: With code 6, `t_out` is 1 exactly when `rn` >= 0 signed. `rm` has no effect.
- R9: With code 7, `t_out` is 1 exactly when `rn` > 0 signed. `rm` has no effect.
- R10: With code 8, `t_out` is 1 when any lane (bits 7:0, 15:8, 23:16, 31:24) of `rn` equals the same lane of `rm`. A match in a single lane, in any position, is enough.
- R11: For every code other than 0, `r0` and `imm8` have no effect on `t_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cmp_op | input | 4 | Comparison selector (encoding in R1) |
| rn | input | 32 | Left-hand register operand |
| rm | input | 32 | Right-hand register operand |
| r0 | input | 32 | Register zero, used by the immediate-equal test |
| imm8 | input | 8 | Raw signed immediate |
| t_out | output | 1 | New condition flag value |

## Verification
Every result is due in the cycle its inputs are applied, because no register lies between any input and `t_out`. The bench changes inputs just after a falling clock edge and reads `t_out` a quarter period later, before the next rising edge. Each reading therefore reflects only the inputs applied in that cycle. To test the "no effect" requirements, the bench alters only the ignored inputs between two readings and expects the flag to stay the same.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    CMP_EQ_IMM = 4'd0,
    CMP_EQ     = 4'd1,
    CMP_UGE    = 4'd2,
    CMP_SGE    = 4'd3,
    CMP_UGT    = 4'd4,
    CMP_SGT    = 4'd5,
    CMP_NNEG   = 4'd6,
    CMP_POS    = 4'd7,
    CMP_ANYB   = 4'd8
  } cmp_op_e;
endpackage

// File: rtl/cmpu_lanes.sv
module cmpu_lanes #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NLANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [NLANES-1:0] lane_hit
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lane_hit[g] = (a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/cmpu_mag.sv
module cmpu_mag #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned MSB = DATA_W - 1
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              eq,
  output logic              gt_u,
  output logic              gt_s
);
  logic [DATA_W:0] diff;
  logic            signs_differ;

  // lhs - rhs with one extra bit; the top bit is the unsigned borrow
  assign diff         = {1'b0, lhs} - {1'b0, rhs};
  assign eq           = (lhs == rhs);
  assign gt_u         = ~diff[DATA_W] & ~eq;
  assign signs_differ = lhs[MSB] ^ rhs[MSB];
  // with differing signs the non-negative side is larger
  assign gt_s         = signs_differ ? ~lhs[MSB] : gt_u;
endmodule

// File: rtl/cmpu_tflag.sv
module cmpu_tflag
  import cmpu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned IMM_W  = 8,
  localparam int unsigned NLANES = DATA_W / LANE_W,
  localparam int unsigned MSB    = DATA_W - 1
) (
  input  logic [OP_W-1:0]   cmp_op,
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] rm,
  input  logic [DATA_W-1:0] r0,
  input  logic [IMM_W-1:0]  imm8,
  output logic              t_out
);
  logic [DATA_W-1:0] imm_ext;
  logic [NLANES-1:0] reg_hit, imm_hit;
  logic              rr_eq, rr_gt_u, rr_gt_s;
  logic              z_eq, z_gt_u, z_gt_s;
  logic              any_byte, imm_eq;

  assign imm_ext = {{(DATA_W-IMM_W){imm8[IMM_W-1]}}, imm8};

  cmpu_mag #(.DATA_W(DATA_W)) u_mag_rr (
    .lhs(rn), .rhs(rm), .eq(rr_eq), .gt_u(rr_gt_u), .gt_s(rr_gt_s));

  cmpu_mag #(.DATA_W(DATA_W)) u_mag_zero (
    .lhs(rn), .rhs('0), .eq(z_eq), .gt_u(z_gt_u), .gt_s(z_gt_s));

  cmpu_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes_rr (
    .a(rn), .b(rm), .lane_hit(reg_hit));

  cmpu_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes_imm (
    .a(r0), .b(imm_ext), .lane_hit(imm_hit));

  assign any_byte = |reg_hit;
  assign imm_eq   = &imm_hit;

  always_comb begin
    case (cmp_op)
      CMP_EQ_IMM: t_out = imm_eq;
      CMP_EQ:     t_out = rr_eq;
      CMP_UGE:    t_out = rr_gt_u | rr_eq;
      CMP_SGE:    t_out = rr_gt_s | rr_eq;
      CMP_UGT:    t_out = rr_gt_u;
      CMP_SGT:    t_out = rr_gt_s;
      CMP_NNEG:   t_out = z_gt_s | z_eq;
      CMP_POS:    t_out = z_gt_s;
      CMP_ANYB:   t_out = any_byte;
      default:    t_out = 1'b0;
    endcase
  end

  // guards relating the separate compare paths
  always_comb begin
    if (cmp_op > OP_W'(CMP_ANYB))
      p_undef_low_r1: assert (!t_out) else $error("undefined code set flag");
    if (cmp_op == CMP_EQ && rn == rm)
      p_self_eq_r2: assert (t_out) else $error("equal operands not flagged");
    if (cmp_op == CMP_UGT && rr_eq)
      p_self_hi_r5: assert (!t_out) else $error("higher on equal operands");
    if (cmp_op == CMP_SGE && !rn[MSB] && rm[MSB])
      p_sign_ge_r6: assert (t_out) else $error("non-negative below negative");
    if (cmp_op == CMP_UGE && rr_gt_u)
      p_hi_implies_hs_r4: assert (t_out) else $error("higher but not same-or-higher");
    if (cmp_op == CMP_ANYB && rr_eq)
      p_full_eq_lanes_r10: assert (t_out) else $error("equal words miss lane match");
    if (cmp_op == CMP_POS && t_out)
      p_pos_nonzero_r9: assert (z_gt_u) else $error("positive flagged on zero");
  end
endmodule

// File: tb/cmpu_tflag_bench.sv
module cmpu_tflag_bench;
  logic        clk = 1'b0;
  logic [3:0]  cmp_op;
  logic [31:0] rn, rm, r0;
  logic [7:0]  imm8;
  logic        t_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cmpu_tflag u_cmpu_tflag (
    .cmp_op(cmp_op), .rn(rn), .rm(rm), .r0(r0), .imm8(imm8), .t_out(t_out));

  function automatic bit ref_t(input logic [3:0] op, input logic [31:0] n,
                               input logic [31:0] m, input logic [31:0] z,
                               input logic [7:0] im);
    longint sn, sm, si;
    bit hit;
    sn = longint'($signed(n));
    sm = longint'($signed(m));
    si = longint'($signed(im));
    case (op)
      4'd0: return longint'($signed(z)) == si;
      4'd1: return n == m;
      4'd2: return {32'd0, n} >= {32'd0, m};
      4'd3: return sn >= sm;
      4'd4: return {32'd0, n} > {32'd0, m};
      4'd5: return sn > sm;
      4'd6: return sn >= 0;
      4'd7: return sn > 0;
      4'd8: begin
        hit = 0;
        for (int k = 0; k < 4; k++)
          if (((n >> (8*k)) & 32'hFF) == ((m >> (8*k)) & 32'hFF)) hit = 1;
        return hit;
      end
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";  4'd1: return "R2";  4'd2: return "R4";
      4'd3: return "R6";  4'd4: return "R5";  4'd5: return "R7";
      4'd6: return "R8";  4'd7: return "R9";  4'd8: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] n,
                       input logic [31:0] m, input logic [31:0] z,
                       input logic [7:0] im);
    @(negedge clk);
    cmp_op = op; rn = n; rm = m; r0 = z; imm8 = im;
    #2;
  endtask

  task automatic check(input string req, input bit exp);
    checks++;
    if (t_out !== exp) begin
      errors++;
      $display("FAIL %s op=%0d rn=%h rm=%h r0=%h imm=%h actual=%b expected=%b",
               req, cmp_op, rn, rm, r0, imm8, t_out, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] n,
                     input logic [31:0] m, input logic [31:0] z,
                     input logic [7:0] im);
    apply(op, n, m, z, im);
    check(req_of(op), ref_t(op, n, m, z, im));
  endtask

  logic [31:0] edges [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  initial begin
    bit prev;
    // R1: initial state with a defined code
    run(4'd1, 32'h0, 32'h0, 32'h0, 8'h0);

    // boundary sweep over every code including undefined ones (R1 to R10)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(4'(op), edges[i], edges[j], edges[i], edges[j][7:0]);

    // R3: immediate sign extension corners
    run(4'd0, 32'hFFFFFF80, 32'h0, 32'hFFFFFF80, 8'h80);
    run(4'd0, 32'h0, 32'h0, 32'h00000080, 8'h80);
    run(4'd0, 32'h0, 32'h0, 32'h0000007F, 8'h7F);
    run(4'd0, 32'h0, 32'h0, 32'hFFFFFFFF, 8'hFF);

    // R10: exactly one lane matching, in each position, and none
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a, b;
      a = 32'h11223344;
      b = ~a;
      b[8*k +: 8] = a[8*k +: 8];
      apply(4'd8, a, b, 32'h0, 8'h0);
      check("R10", 1'b1);
    end
    apply(4'd8, 32'h61626364, 32'h00000000, 32'h0, 8'h0);
    check("R10", 1'b0);
    apply(4'd8, 32'h61006364, 32'h00000000, 32'h0, 8'h0);
    check("R10", 1'b1);

    // random operands against the model
    for (int t = 0; t < 2000; t++)
      run(4'($urandom_range(0, 9)), $urandom, $urandom, $urandom, 8'($urandom));

    // R8 / R9: rm has no effect
    for (int op = 6; op < 8; op++) begin
      apply(4'(op), 32'h5, 32'h0, 32'h0, 8'h0);
      prev = t_out;
      apply(4'(op), 32'h5, 32'hFFFFFFFF, 32'h0, 8'h0);
      check(op == 6 ? "R8" : "R9", prev);
    end

    // R11: r0 and imm8 have no effect outside code 0
    for (int op = 1; op < 9; op++) begin
      apply(4'(op), 32'h80000001, 32'h00000001, 32'h0, 8'h00);
      prev = t_out;
      apply(4'(op), 32'h80000001, 32'h00000001, 32'hDEADBEEF, 8'hA5);
      check("R11", prev);
    end
    // R3: rn and rm have no effect with code 0
    apply(4'd0, 32'h0, 32'h0, 32'h12, 8'h12);
    prev = t_out;
    apply(4'd0, 32'hFFFFFFFF, 32'h7, 32'h12, 8'h12);
    check("R3", prev);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule